// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block recovers low-speed USB packets from a pair of already synchronised line inputs. Its clock runs at twelve times the line bit rate, so every bit spans twelve clock cycles. While the line rests in the J state, the block waits for a J-to-K transition on D-. It then tracks the alternating sync pattern and re-locks its bit phase to each new falling D- edge. The sync field is taken as complete when a second K in a row is seen at a bit centre.

After sync, every bit is sampled on a fixed twelve-clock grid at the bit centre. Each bit is NRZI-decoded and freed of stuffed bits, then shifted into bytes least-significant bit first. The first byte is the packet identifier. Its two nibbles must be bitwise complements. Every byte is reported by a one-cycle strobe, and the identifier is additionally qualified by a valid flag when its nibbles check out.

The packet ends when an SE0 is seen at a sample point. Any error collected during the packet is reported together with that end pulse. Error sources are a bad identifier, a stuffing violation, too many bytes, or a packet that ends without an identifier.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is held and after it is released with the line idle (J: D+ low, D- high), all output strobes and flags are low.
- R2: pkt_start_o pulses for one cycle exactly 19 clock cycles after the falling D- edge that begins the final two-K pair of sync is applied. This is the cycle after the second K is sampled, 18 clocks after the edge is seen.
- R3: Data bits are sampled every 12 clocks starting 30 clocks after that edge. A bit is 1 when D- equals its value at the previous sample and 0 when it differs. Bits are packed least-significant first, and each completed byte gives one byte_vld_o pulse with the value on byte_o.
- R4: The first byte after sync is the identifier. pid_vld_o pulses with its byte_vld_o only when bits [7:4] equal the complement of bits [3:0]. Otherwise pkt_err_o is raised at packet end.
- R5: After six consecutive decoded 1s (counting the final sync bit as one 1), the next bit is discarded and not shifted into a byte.
- R6: If the discarded bit is a 1, the packet ends with pkt_err_o. A stuffing condition inside the identifier byte is also an error.
- R7: An SE0 (both lines low) at a sample point gives one pkt_end_o pulse. pkt_err_o can only be high together with pkt_end_o. A packet that ends before a full identifier byte is an error.
- R8: Beyond BUF_BYTES data bytes after the identifier, further bytes are not strobed, and pkt_err_o is raised at packet end.
- R9: During sync search, if no falling D- edge arrives within HUNT_TO clocks of the previous one, the block returns to idle with no pkt_start_o.
- R10: When a falling D- edge is seen in the same cycle in which the search counter reaches HUNT_TO, the edge wins and the search re-locks to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at 12x the line bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Synchronised D+ line |
| dm_i | input | 1 | Synchronised D- line |
| byte_vld_o | output | 1 | One-cycle strobe for a received byte |
| byte_o | output | 8 | Received byte value |
| pid_vld_o | output | 1 | Identifier byte passed the nibble-complement check |
| pkt_start_o | output | 1 | Sync completed, packet begins |
| pkt_end_o | output | 1 | SE0 seen, packet ends |
| pkt_err_o | output | 1 | Packet had an error (with pkt_end_o) |

## Verification
The search timeout and a fresh falling D- edge can land in the same clock cycle. The bench provokes this by holding J for exactly the timeout span after a sync K, so that the final K-K pair starts on the limit cycle. The outcome is judged at the ports: if the edge is honoured, the packet's start pulse appears and the identifier is accepted without error. If the timeout is honoured instead, that K edge is lost, the lock lands inside the identifier bits, and the identifier check fails.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  localparam int STUFF_RUN = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_RX   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync
  import usb_ls_rx_pkg::*;
#(
  parameter int BIT_CLKS = 12,
  parameter int HUNT_TO  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  output logic samp_o,
  output logic start_o
);
  localparam int HALF  = BIT_CLKS / 2;
  localparam int K2_AT = HALF + BIT_CLKS;
  localparam int CW    = $clog2(HUNT_TO + 1);
  localparam int PW    = $clog2(BIT_CLKS);

  rx_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   ph_q;
  logic            dm_q;

  logic fall, is_k, se0;
  assign fall = dm_q & ~dm_i & dp_i;
  assign is_k = dp_i & ~dm_i;
  assign se0  = ~dp_i & ~dm_i;

  assign samp_o  = (state_q == ST_RX) && (ph_q == '0);
  assign start_o = (state_q == ST_HUNT) && !fall && (cnt_q == CW'(K2_AT)) && is_k;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ph_q    <= '0;
      dm_q    <= 1'b1;
    end else begin
      dm_q <= dm_i;
      unique case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q <= ST_HUNT;
            cnt_q   <= CW'(1);
          end
        end
        ST_HUNT: begin
          // newest edge always re-locks the phase, even on the limit cycle
          if (fall) begin
            cnt_q <= CW'(1);
          end else if (cnt_q == CW'(HALF) && !is_k) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == CW'(K2_AT) && is_k) begin
            state_q <= ST_RX;
            ph_q    <= PW'(1);
          end else if (cnt_q == CW'(K2_AT) && se0) begin
            state_q <= ST_IDLE;
          end else if (cnt_q >= CW'(HUNT_TO)) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_RX: begin
          ph_q <= (ph_q == PW'(BIT_CLKS - 1)) ? '0 : ph_q + PW'(1);
          if (samp_o && se0) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) |-> (cnt_q <= CW'(HUNT_TO))); // R9
  AST_START_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (state_q == ST_RX && !start_o)); // R2
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && fall) |=> (state_q == ST_HUNT && cnt_q == CW'(1))); // R10
endmodule

// File: rtl/usb_ls_rx_decode.sv
module usb_ls_rx_decode
  import usb_ls_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic samp_i,
  input  logic dp_i,
  input  logic dm_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic stuff_o,
  output logic stuff_err_o,
  output logic se0_o
);
  localparam int OW = $clog2(STUFF_RUN + 1);

  logic          prev_dm_q;
  logic [OW-1:0] ones_q;
  logic          se0, live, at_run;

  assign se0    = ~dp_i & ~dm_i;
  assign live   = samp_i & ~se0;
  assign at_run = (ones_q == OW'(STUFF_RUN));

  assign bit_o       = (dm_i == prev_dm_q);
  assign stuff_o     = live & at_run;
  assign bit_vld_o   = live & ~at_run;
  assign stuff_err_o = stuff_o & bit_o;
  assign se0_o       = samp_i & se0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_dm_q <= 1'b0;
      ones_q    <= '0;
    end else if (start_i) begin
      prev_dm_q <= 1'b0;      // line is K at end of sync
      ones_q    <= OW'(1);    // last sync bit decodes as 1
    end else if (live) begin
      prev_dm_q <= dm_i;
      ones_q    <= (!at_run && bit_o) ? ones_q + OW'(1) : '0;
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= OW'(STUFF_RUN)); // R5
  AST_DROP_RESETS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_o && !start_i) |=> (ones_q == '0)); // R5
endmodule

// File: rtl/usb_ls_rx_bytes.sv
module usb_ls_rx_bytes #(
  parameter int BUF_BYTES = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  input  logic       stuff_i,
  input  logic       stuff_err_i,
  input  logic       se0_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       pid_vld_o,
  output logic       pkt_start_o,
  output logic       pkt_end_o,
  output logic       pkt_err_o
);
  localparam int NW = $clog2(BUF_BYTES + 1);

  logic [6:0]    sh_q;
  logic [2:0]    bcnt_q;
  logic          pid_done_q;
  logic [NW-1:0] nbytes_q;
  logic          err_q;
  logic [7:0]    data;

  assign data = {bit_i, sh_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      bcnt_q      <= '0;
      pid_done_q  <= 1'b0;
      nbytes_q    <= '0;
      err_q       <= 1'b0;
      byte_vld_o  <= 1'b0;
      byte_o      <= '0;
      pid_vld_o   <= 1'b0;
      pkt_start_o <= 1'b0;
      pkt_end_o   <= 1'b0;
      pkt_err_o   <= 1'b0;
    end else begin
      byte_vld_o  <= 1'b0;
      pid_vld_o   <= 1'b0;
      pkt_start_o <= start_i;
      pkt_end_o   <= 1'b0;
      pkt_err_o   <= 1'b0;
      if (start_i) begin
        sh_q       <= '0;
        bcnt_q     <= '0;
        pid_done_q <= 1'b0;
        nbytes_q   <= '0;
        err_q      <= 1'b0;
      end else if (se0_i) begin
        pkt_end_o <= 1'b1;
        pkt_err_o <= err_q | ~pid_done_q;
      end else begin
        if (stuff_err_i || (stuff_i && !pid_done_q)) err_q <= 1'b1;
        if (bit_vld_i) begin
          sh_q   <= data[7:1];
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            if (!pid_done_q) begin
              pid_done_q <= 1'b1;
              byte_vld_o <= 1'b1;
              byte_o     <= data;
              if (data[7:4] == ~data[3:0]) pid_vld_o <= 1'b1;
              else                         err_q     <= 1'b1;
            end else if (nbytes_q == NW'(BUF_BYTES)) begin
              err_q <= 1'b1;
            end else begin
              nbytes_q   <= nbytes_q + NW'(1);
              byte_vld_o <= 1'b1;
              byte_o     <= data;
            end
          end
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbytes_q <= NW'(BUF_BYTES)); // R8
  AST_PID_WITH_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_vld_o |-> (byte_vld_o && byte_o[7:4] == ~byte_o[3:0])); // R4
  AST_ERR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_err_o |-> pkt_end_o); // R7
  AST_END_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> (!byte_vld_o && !pkt_start_o)); // R7
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
  parameter int BIT_CLKS  = 12,
  parameter int HUNT_TO   = 30,
  parameter int BUF_BYTES = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       pid_vld_o,
  output logic       pkt_start_o,
  output logic       pkt_end_o,
  output logic       pkt_err_o
);
  logic samp, start, bit_vld, bit_val, stuff, stuff_err, se0;

  usb_ls_rx_sync #(.BIT_CLKS(BIT_CLKS), .HUNT_TO(HUNT_TO)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dp_i    (dp_i),
    .dm_i    (dm_i),
    .samp_o  (samp),
    .start_o (start)
  );

  usb_ls_rx_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .samp_i      (samp),
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .bit_vld_o   (bit_vld),
    .bit_o       (bit_val),
    .stuff_o     (stuff),
    .stuff_err_o (stuff_err),
    .se0_o       (se0)
  );

  usb_ls_rx_bytes #(.BUF_BYTES(BUF_BYTES)) u_bytes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .bit_vld_i   (bit_vld),
    .bit_i       (bit_val),
    .stuff_i     (stuff),
    .stuff_err_i (stuff_err),
    .se0_i       (se0),
    .byte_vld_o  (byte_vld_o),
    .byte_o      (byte_o),
    .pid_vld_o   (pid_vld_o),
    .pkt_start_o (pkt_start_o),
    .pkt_end_o   (pkt_end_o),
    .pkt_err_o   (pkt_err_o)
  );
endmodule

// File: tb/tb_usb_ls_rx.sv
module tb_usb_ls_rx;
  localparam int HUNT_TO   = 30;
  localparam int BUF_BYTES = 10;
  localparam int LK = 0, LJ = 1, LSE0 = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dp = 1'b0, dm = 1'b1;
  logic byte_vld, pid_vld, pkt_start, pkt_end, pkt_err;
  logic [7:0] byte_v;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  usb_ls_rx #(.BIT_CLKS(12), .HUNT_TO(HUNT_TO), .BUF_BYTES(BUF_BYTES)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dp_i(dp), .dm_i(dm),
    .byte_vld_o(byte_vld), .byte_o(byte_v), .pid_vld_o(pid_vld),
    .pkt_start_o(pkt_start), .pkt_end_o(pkt_end), .pkt_err_o(pkt_err)
  );

  int checks = 0, errors = 0;
  logic [7:0] rx [0:31];
  int n_rx, n_pid, n_start, n_end, n_err, start_cyc, t0;
  int cur, ones;
  bit stuff_en;
  bit done = 0;

  always @(negedge clk) if (rst_ni) begin
    if (byte_vld) begin
      if (n_rx < 32) rx[n_rx] = byte_v;
      n_rx++;
    end
    if (pid_vld) n_pid++;
    if (pkt_start) begin n_start++; start_cyc = cyc; end
    if (pkt_end) n_end++;
    if (pkt_err) n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear();
    n_rx = 0; n_pid = 0; n_start = 0; n_end = 0; n_err = 0; start_cyc = 0;
  endtask

  task automatic drive(input int lv, input int n);
    case (lv)
      LK:      begin dp = 1'b1; dm = 1'b0; end
      LJ:      begin dp = 1'b0; dm = 1'b1; end
      default: begin dp = 1'b0; dm = 1'b0; end
    endcase
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input bit b);
    if (!b) cur = 1 - cur;
    drive(cur, 12);
    ones = b ? ones + 1 : 0;
    if (stuff_en && ones == 6) begin
      cur = 1 - cur;
      drive(cur, 12);
      ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic send_sync();
    drive(LK, 12); drive(LJ, 12); drive(LK, 12); drive(LJ, 12);
    drive(LK, 12); drive(LJ, 12);
    t0 = cyc;
    drive(LK, 24);
    cur = LK; ones = 1;
  endtask

  task automatic send_eop();
    drive(LSE0, 24); drive(LJ, 12); cur = LJ; drive(LJ, 24);
  endtask

  task automatic t_reset();
    chk(!byte_vld && !pid_vld && !pkt_start && !pkt_end && !pkt_err, "R1 idle outputs",
        {byte_vld, pid_vld, pkt_start, pkt_end, pkt_err}, 0);
  endtask

  task automatic t_good();
    clear(); stuff_en = 1;
    send_sync(); send_byte(8'hC3); send_byte(8'h55); send_byte(8'hA0); send_eop();
    chk(n_start == 1, "R2 start count", n_start, 1);
    chk(start_cyc - t0 == 19, "R2 start latency", start_cyc - t0, 19);
    chk(n_rx == 3, "R3 byte count", n_rx, 3);
    chk(rx[0] == 8'hC3, "R3 pid byte", rx[0], 8'hC3);
    chk(rx[1] == 8'h55 && rx[2] == 8'hA0, "R3 data bytes", {rx[1], rx[2]}, 16'h55A0);
    chk(n_pid == 1, "R4 pid valid", n_pid, 1);
    chk(n_end == 1 && n_err == 0, "R7 clean end", n_end * 10 + n_err, 10);
  endtask

  task automatic t_stuff();
    clear(); stuff_en = 1;
    send_sync(); send_byte(8'h4B); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h7E);
    send_eop();
    chk(n_rx == 4, "R5 byte count", n_rx, 4);
    chk(rx[1] == 8'hFF && rx[2] == 8'hFF && rx[3] == 8'h7E, "R5 unstuffed data",
        {rx[1], rx[2], rx[3]}, 24'hFFFF7E);
    chk(n_err == 0 && n_pid == 1, "R5 no error", n_err, 0);
  endtask

  task automatic t_bad_pid();
    clear(); stuff_en = 1;
    send_sync(); send_byte(8'h5B); send_byte(8'h12); send_eop();
    chk(n_pid == 0, "R4 bad pid not valid", n_pid, 0);
    chk(n_err == 1, "R4 bad pid error", n_err, 1);
    chk(n_rx == 2, "R3 bytes still strobed", n_rx, 2);
  endtask

  task automatic t_stuff_err();
    clear(); stuff_en = 1;
    send_sync(); send_byte(8'hC3);
    stuff_en = 0;
    send_byte(8'hFF); send_byte(8'hFF);
    stuff_en = 1;
    send_eop();
    chk(n_pid == 1, "R6 pid ok", n_pid, 1);
    chk(n_err == 1, "R6 stuff error", n_err, 1);
  endtask

  task automatic t_no_pid();
    clear(); stuff_en = 1;
    send_sync(); send_eop();
    chk(n_end == 1 && n_rx == 0, "R7 end without bytes", n_end * 10 + n_rx, 10);
    chk(n_err == 1, "R7 missing pid error", n_err, 1);
  endtask

  task automatic t_ovf();
    clear(); stuff_en = 1;
    send_sync(); send_byte(8'hC3);
    for (int i = 0; i < BUF_BYTES + 1; i++) send_byte(8'h10 + 8'(i));
    send_eop();
    chk(n_rx == BUF_BYTES + 1, "R8 strobes capped", n_rx, BUF_BYTES + 1);
    chk(rx[BUF_BYTES] == 8'h10 + 8'(BUF_BYTES - 1), "R8 last kept byte",
        rx[BUF_BYTES], 8'h10 + BUF_BYTES - 1);
    chk(n_err == 1, "R8 overflow error", n_err, 1);
  endtask

  task automatic t_timeout();
    clear(); stuff_en = 1;
    drive(LK, 12); drive(LJ, 60);
    chk(n_start == 0 && n_end == 0, "R9 no start after timeout", n_start + n_end, 0);
    send_sync(); send_byte(8'hD2); send_eop();
    chk(n_start == 1 && n_pid == 1 && n_err == 0, "R9 recovers",
        n_start * 100 + n_pid * 10 + n_err, 110);
  endtask

  task automatic t_race();
    clear(); stuff_en = 1;
    drive(LK, 12); drive(LJ, HUNT_TO - 12);
    drive(LK, 24); cur = LK; ones = 1;
    send_byte(8'hC3); send_byte(8'h33); send_eop();
    chk(n_start == 1, "R10 edge on limit cycle locks", n_start, 1);
    chk(n_pid == 1 && n_err == 0, "R10 pid intact", n_pid * 10 + n_err, 10);
    chk(n_rx == 2 && rx[1] == 8'h33, "R10 data intact", rx[1], 8'h33);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_good();
    t_stuff();
    t_bad_pid();
    t_stuff_err();
    t_no_pid();
    t_ovf();
    t_timeout();
    t_race();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule